// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-clock static RAM whose words are 36 bits wide, split into four 9-bit byte lanes. Address, chip select, write strobe and byte enables are registered on the rising clock edge. The write data for a write cycle arrives one clock later than its address. Reads return their word through an output register one edge after the address is taken.

A one-entry posted-write buffer holds the most recent write until the array can take it. An address comparator merges the buffered lanes into any read of the same word, so a read always returns the newest data. The pin drivers are modelled by a drive-enable output. A write switches the drive off at once. A deselect switches it off one edge later. An asynchronous active-low output enable and a sleep input also gate the drive.

The interface runs at a fixed latency with no valid/ready handshake and no back-pressure. A command presented at an edge is accepted unless sleep is high. The host must leave one idle cycle between a read and a following write. The core flags a write that breaks this rule and still performs it.

Top module: `late_write_sram`

## Requirements
- R1: Controls and address are captured on the rising edge. The word for a read captured at edge k is in `rdata_o` after edge k+1, and `rdata_o` changes only at edges that complete a read.
- R2: For a write captured at edge k, `wdata_i` is sampled at edge k+1, whether or not sleep is high at that edge.
- R3: A read always returns the newest data. This includes a read captured at the edge at which the preceding write's data arrives, and also holds when only some lanes were written.
- R4: Lane i is bits [9i+8:9i]. It is written only when `byte_en_n_i[i]` is low at the write's capture edge.
- R5: Byte enables have no effect on reads.
- R6: A write with all byte enables high changes no stored word, but it turns the drive off just like any other write.
- R7: `drive_en_o` is high only after an edge that completed a read. It drops in the cycle after a write is captured, and it drops one edge after a deselect is captured.
- R8: `oe_n_i` high forces `drive_en_o` low with no clock edge needed.
- R9: While `sleep_i` is high, `drive_en_o` is low and no command is accepted. Stored words and any pending buffered write are kept.
- R10: A write captured at the edge right after an accepted read raises `proto_err_o` for one cycle. The write is still performed.
- R11: After reset, `drive_en_o`, `proto_err_o` and `rdata_o` are zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep; blocks new commands and the drive |
| sel_n_i | input | 1 | Chip select, active low, registered |
| wr_n_i | input | 1 | Write strobe, active low, registered |
| byte_en_n_i | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, one edge after its address |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Output register |
| drive_en_o | output | 1 | Output drivers enabled |
| proto_err_o | output | 1 | Write directly after read |

## Verification
The hardest case to reach from the ports is a read that depends on the buffered write instead of the array. Two examples are a partial write followed at once by a read of the same word, and a write whose data arrived just before a sleep stretch and then stays pending until wake-up. To reach these often, the stimulus keeps addresses within sixteen words and mixes bursts of sleep into the random traffic. It also runs directed sequences for partial-lane forwarding, writes with no lane enabled, and retention of data across sleep. The expected values come from a word-level model that applies a write when its data arrives, so any forwarding error shows up as a mismatch on `rdata_o`.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              sel_n_i,
  input  logic              wr_n_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cyc_e              cyc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic              proto_err_o
);
  logic accept;
  assign accept = !sleep_i && !sel_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_o       <= CYC_IDLE;
      addr_o      <= '0;
      be_o        <= '0;
      proto_err_o <= 1'b0;
    end else begin
      proto_err_o <= accept && !wr_n_i && (cyc_o == CYC_READ);
      if (accept) begin
        cyc_o  <= wr_n_i ? CYC_READ : CYC_WRITE;
        addr_o <= addr_i;
        be_o   <= ~be_n_i;
      end else begin
        cyc_o  <= CYC_IDLE;
      end
    end
  end

  // R9
  sleep_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (cyc_o == CYC_IDLE));

  // R10
  err_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> (cyc_o == CYC_WRITE));
endmodule

// File: rtl/lw_lane_array.sv
module lw_lane_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_i,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic [LANES*LANE_W-1:0] arr_data_i,
  output logic                    commit_o,
  output logic [ADDR_W-1:0]       cm_addr_o,
  output logic [LANES*LANE_W-1:0] cm_data_o,
  output logic [LANES-1:0]        cm_be_o,
  output logic [LANES*LANE_W-1:0] fwd_data_o
);
  logic                    pend_q;
  logic [ADDR_W-1:0]       pend_addr_q;
  logic [LANES*LANE_W-1:0] pend_data_q;
  logic [LANES-1:0]        pend_be_q;
  logic                    hit;

  // The pending entry retires at the next accepted cycle or when replaced.
  assign commit_o  = pend_q && (load_i || !sleep_i);
  assign cm_addr_o = pend_addr_q;
  assign cm_data_o = pend_data_q;
  assign cm_be_o   = pend_be_q;
  assign hit       = pend_q && (pend_addr_q == rd_addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_be_q   <= '0;
    end else if (load_i) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr_i;
      pend_data_q <= wdata_i;
      pend_be_q   <= be_i;
    end else if (commit_o) begin
      pend_q      <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign fwd_data_o[g*LANE_W +: LANE_W] = (hit && pend_be_q[g]) ?
        pend_data_q[g*LANE_W +: LANE_W] : arr_data_i[g*LANE_W +: LANE_W];
  end

  // R2
  late_data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pend_q && (pend_data_q == $past(wdata_i))));

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && sleep_i && !load_i) |=> (pend_q && $stable(pend_addr_q) && $stable(pend_data_q)));
endmodule

// File: rtl/lw_out_ctrl.sv
module lw_out_ctrl #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done_i,
  input  logic              wr_now_i,
  input  logic              sleep_i,
  input  logic              oe_n_i,
  input  logic [WORD_W-1:0] fwd_data_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_en_o
);
  logic drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      drv_q <= rd_done_i;
      if (rd_done_i) rdata_o <= fwd_data_i;
    end
  end

  assign drive_en_o = drv_q && !wr_now_i && !oe_n_i && !sleep_i;

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done_i |=> $stable(rdata_o));

  // R7
  drive_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_o |-> $past(rd_done_i));
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_i,
  input  logic                    sel_n_i,
  input  logic                    wr_n_i,
  input  logic [LANES-1:0]        byte_en_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_n_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_en_o,
  output logic                    proto_err_o
);
  localparam int WORD_W = LANES * LANE_W;

  cyc_e              cyc;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_be;
  logic              commit;
  logic [ADDR_W-1:0] cm_addr;
  logic [WORD_W-1:0] cm_data;
  logic [LANES-1:0]  cm_be;
  logic [WORD_W-1:0] arr_data;
  logic [WORD_W-1:0] fwd_data;

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel_n_i(sel_n_i),
    .wr_n_i(wr_n_i), .be_n_i(byte_en_n_i), .addr_i(addr_i),
    .cyc_o(cyc), .addr_o(cur_addr), .be_o(cur_be), .proto_err_o(proto_err_o)
  );

  lw_write_buffer #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .load_i(cyc == CYC_WRITE), .addr_i(cur_addr), .be_i(cur_be),
    .wdata_i(wdata_i), .rd_addr_i(cur_addr), .arr_data_i(arr_data),
    .commit_o(commit), .cm_addr_o(cm_addr), .cm_data_o(cm_data),
    .cm_be_o(cm_be), .fwd_data_o(fwd_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lw_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .we_i(commit && cm_be[g]), .waddr_i(cm_addr),
      .wdata_i(cm_data[g*LANE_W +: LANE_W]), .raddr_i(cur_addr),
      .rdata_o(arr_data[g*LANE_W +: LANE_W])
    );
  end

  lw_out_ctrl #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_done_i(cyc == CYC_READ),
    .wr_now_i(cyc == CYC_WRITE), .sleep_i(sleep_i), .oe_n_i(oe_n_i),
    .fwd_data_i(fwd_data), .rdata_o(rdata_o), .drive_en_o(drive_en_o)
  );
endmodule

// File: tb/sim_late_write_sram.sv
module sim_late_write_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_i = 1'b0, sel_n_i = 1'b1, wr_n_i = 1'b1, oe_n_i = 1'b1;
  logic [3:0]  byte_en_n_i = 4'hF;
  logic [9:0]  addr_i = '0;
  logic [35:0] wdata_i = '0;
  logic [35:0] rdata_o;
  logic        drive_en_o, proto_err_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [35:0] lmem [16];
  int          m_cyc = 0;          // 0 idle, 1 read, 2 write
  logic [3:0]  m_addr = '0;
  logic [3:0]  m_be = '0;
  logic [35:0] m_rdata = '0;
  logic        m_drv = 0, m_err = 0;

  always #5 clk = ~clk;

  late_write_sram u0 (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel_n_i(sel_n_i),
    .wr_n_i(wr_n_i), .byte_en_n_i(byte_en_n_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .oe_n_i(oe_n_i), .rdata_o(rdata_o),
    .drive_en_o(drive_en_o), .proto_err_o(proto_err_o)
  );

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] be);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_now(string tag);
    logic e_drv = m_drv && (m_cyc != 2) && !oe_n_i && !sleep_i;
    chk(tag, "rdata", rdata_o, m_rdata);
    chk(tag, "drive", {35'd0, drive_en_o}, {35'd0, e_drv});
    chk(tag, "proto_err", {35'd0, proto_err_o}, {35'd0, m_err});
  endtask

  // called at a negedge: check, drive, advance one edge, update model
  task automatic step(string tag, logic sl, logic sn, logic wn, logic [3:0] ben,
                      logic [3:0] ad, logic oen);
    logic [35:0] wd = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
    check_now(tag);
    sleep_i = sl; sel_n_i = sn; wr_n_i = wn; byte_en_n_i = ben;
    addr_i = {6'd0, ad}; oe_n_i = oen; wdata_i = wd;
    @(posedge clk);
    if (m_cyc == 2) lmem[m_addr] = merge(lmem[m_addr], wd, m_be);
    if (m_cyc == 1) m_rdata = lmem[m_addr];
    m_err = !sl && !sn && !wn && (m_cyc == 1);
    m_drv = (m_cyc == 1);
    if (!sl && !sn) begin
      m_cyc = wn ? 1 : 2; m_addr = ad; m_be = ~ben;
    end else m_cyc = 0;
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 1, 1, 4'hF, 4'd0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: state out of reset
    idle("R11");
    idle("R11");
    // fill words 0..15 with full writes (R2, R4)
    for (int a = 0; a < 16; a++) step("R2", 0, 0, 0, 4'h0, 4'(a), 0);
    idle("R2");
    for (int a = 0; a < 16; a++) step("R1", 0, 0, 1, 4'h0, 4'(a), 0);
    idle("R1");
    // R3 R4: partial write to lanes 0 and 2, immediate read of same word
    step("R4", 0, 0, 0, 4'b1010, 4'd3, 0);
    step("R3", 0, 0, 1, 4'hF, 4'd3, 0);
    step("R3", 0, 0, 1, 4'h0, 4'd3, 0);
    idle("R3"); idle("R3");
    // R5: byte enables ignored on read
    step("R5", 0, 0, 1, 4'b0101, 4'd9, 0);
    idle("R5"); idle("R5");
    // R6: write with no lane enabled, then read back
    step("R6", 0, 0, 1, 4'h0, 4'd5, 0);
    idle("R6");
    step("R6", 0, 0, 0, 4'hF, 4'd5, 0);
    step("R6", 0, 0, 1, 4'h0, 4'd5, 0);
    idle("R6"); idle("R6");
    // R10: write directly after read, still performed
    step("R10", 0, 0, 1, 4'h0, 4'd1, 0);
    step("R10", 0, 0, 0, 4'h0, 4'd1, 0);
    step("R10", 0, 0, 1, 4'h0, 4'd1, 0);
    idle("R10"); idle("R10");
    // R7: deselect after read keeps drive one more cycle
    step("R7", 0, 0, 1, 4'h0, 4'd2, 0);
    idle("R7"); idle("R7"); idle("R7");
    // R8: asynchronous output enable
    step("R8", 0, 0, 1, 4'h0, 4'd4, 0);
    step("R8", 0, 1, 1, 4'hF, 4'd0, 0);
    oe_n_i = 1'b1; #1 check_now("R8");
    oe_n_i = 1'b0; #1 check_now("R8");
    idle("R8");
    // R9: write, sleep while data arrives, commands ignored in sleep
    step("R9", 0, 0, 0, 4'b0011, 4'd7, 0);
    step("R9", 1, 0, 0, 4'h0, 4'd7, 0);
    for (int i = 0; i < 4; i++) step("R9", 1, 0, 0, 4'h0, 4'(i + 7), 0);
    step("R9", 0, 0, 1, 4'h0, 4'd7, 0);
    step("R9", 0, 0, 1, 4'h0, 4'd8, 0);
    idle("R9"); idle("R9");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic sl = ($urandom % 12) == 0;
      logic sn = ($urandom % 5) == 0;
      logic wn = ($urandom % 2) == 0;
      logic oen = ($urandom % 8) == 0;
      step("R1 R3 R4 R7 R9 R10", sl, sn, wn, 4'($urandom), 4'($urandom), oen);
    end
    idle("R3");
    check_now("R3");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule